// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer

This block keeps the program order of instructions in an out-of-order core. Each issued instruction takes one slot of a circular buffer. Up to two slots are granted per cycle, and the oldest request takes the lower tag. A slot is marked finished in one of two ways. For an ordinary instruction, its tag appears on the single result bus together with the value. For a store, a separate done strobe reports that the memory write has happened.

Retirement happens only at the head of the buffer, and at most two slots retire in a cycle. A slot that finishes in cycle N retires in cycle N+1 at the earliest. A finished younger slot stays in place until every older slot has left. A synchronous flush empties the buffer in one cycle. Commit has no backpressure: whatever the commit port shows in a cycle leaves the buffer at the end of that cycle.

Top module: `dual_commit_rob`

## Requirements
- R1: While reset is held, and after it is released, `count` is 0, `full` is 0, both commit valids are 0 and `alloc_tag0` is 0.
- R2: `alloc_tag0` shows the tail slot and `alloc_tag1` shows the tail plus one. A granted two-wide request places slot 0 (the older one) at `alloc_tag0` and slot 1 at `alloc_tag1`.
- R3: `alloc_ready` is 1 exactly when the number of free slots (DEPTH minus `count`) is at least the number of set bits in `alloc_valid`. When it is 0, nothing is allocated.
- R4: `commit_valid[0]` is 1 exactly when the head slot is occupied and finished. A completion sampled at edge N makes its slot retirable from the cycle after N onwards, never during cycle N itself.
- R5: The commit port shows slots strictly in allocation order. Lane 0 carries the head slot and lane 1 the slot after it. Each lane carries that slot's destination index and its result value.
- R6: `commit_valid[1]` is 1 exactly when lane 0 commits and the next slot is also occupied and finished. When it is 1, both slots retire in the same cycle.
- R7: A slot allocated with its store bit set is finished only by `st_done_valid`. It retires with `commit_is_store` set to 1 and `commit_data` equal to 0.
- R8: `count` equals the number of occupied slots, and `full` is 1 exactly when `count` equals DEPTH.
- R9: The tail and head wrap modulo DEPTH, so a tail of DEPTH-1 gives `alloc_tag1` = 0.
- R10: A cycle with `flush` high leaves `count` at 0, both commit valids at 0 and `alloc_tag0` at 0 in the next cycle. This holds whatever else was requested in the flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of every slot |
| alloc_valid | input | 2 | Allocation requests; bit 0 is the older one |
| alloc_is_store0 | input | 1 | Store marker for request 0 |
| alloc_is_store1 | input | 1 | Store marker for request 1 |
| alloc_dst0 | input | REG_W | Destination register of request 0 |
| alloc_dst1 | input | REG_W | Destination register of request 1 |
| alloc_ready | output | 1 | Enough free slots for the current request |
| alloc_tag0 | output | TAG_W | Tag that request 0 receives |
| alloc_tag1 | output | TAG_W | Tag that request 1 receives |
| cmpl_valid | input | 1 | Result bus strobe |
| cmpl_tag | input | TAG_W | Slot that the bus result belongs to |
| cmpl_data | input | DATA_W | Result value |
| st_done_valid | input | 1 | Store write finished |
| st_done_tag | input | TAG_W | Slot of the finished store |
| commit_valid | output | 2 | Retire lanes; bit 0 is the oldest |
| commit_dst0 | output | REG_W | Destination of lane 0 |
| commit_dst1 | output | REG_W | Destination of lane 1 |
| commit_data0 | output | DATA_W | Value of lane 0 |
| commit_data1 | output | DATA_W | Value of lane 1 |
| commit_is_store | output | 2 | Store marker per lane |
| count | output | CNT_W | Occupied slots |
| full | output | 1 | Every slot occupied |

## Verification
The assertions rely on the following input rules:
- Bit 1 of `alloc_valid` is only set together with bit 0.
- The result bus only names occupied, unfinished, non-store slots.
- `st_done_tag` only names occupied, unfinished store slots.
- `cmpl_valid` is never given for the head slot in a cycle in which that slot already retires.

The stimulus draws every completion tag from the bench's own list of occupied, unfinished slots of the matching kind. It builds allocation patterns only as none, slot 0 alone, or both slots. As a result, each input rule holds by construction of the stimulus.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Slot index advanced by k, modulo the buffer depth.
  function automatic int wrap_add(input int p, input int k, input int depth);
    return (p + k) % depth;
  endfunction

  // Number of slots a two-wide request asks for.
  function automatic int req_count(input logic [1:0] v);
    return int'(v[0]) + int'(v[1]);
  endfunction

  // True when the free slots cover the request.
  function automatic bit room_for(input int used, input int want, input int depth);
    return (depth - used) >= want;
  endfunction

endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic [1:0]       alloc_valid,
  input  logic [CNT_W-1:0] count,
  output logic             alloc_ready,
  output logic [1:0]       n_alloc
);

  int want;

  always_comb begin
    want        = rob_pkg::req_count(alloc_valid);
    alloc_ready = rob_pkg::room_for(int'(count), want, DEPTH);
    n_alloc     = alloc_ready ? 2'(want) : 2'd0;
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input  logic [TAG_W-1:0] head,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic [DEPTH-1:0] done_vec,
  output logic [TAG_W-1:0] idx0,
  output logic [TAG_W-1:0] idx1,
  output logic [1:0]       commit_valid,
  output logic [1:0]       n_commit
);

  logic ok0, ok1;

  always_comb begin
    idx0            = head;
    idx1            = TAG_W'(rob_pkg::wrap_add(int'(head), 1, DEPTH));
    ok0             = valid_vec[idx0] && done_vec[idx0];
    ok1             = ok0 && valid_vec[idx1] && done_vec[idx1];
    commit_valid    = {ok1, ok0};
    n_commit        = 2'(int'(ok0) + int'(ok1));
  end

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 3,
  parameter int REG_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        wr_en,
  input  logic [TAG_W-1:0]  wr_idx0,
  input  logic [TAG_W-1:0]  wr_idx1,
  input  logic [1:0]        wr_store,
  input  logic [REG_W-1:0]  wr_dst0,
  input  logic [REG_W-1:0]  wr_dst1,
  input  logic              cmpl_en,
  input  logic [TAG_W-1:0]  cmpl_idx,
  input  logic [DATA_W-1:0] cmpl_data,
  input  logic              sd_en,
  input  logic [TAG_W-1:0]  sd_idx,
  input  logic [1:0]        clr_en,
  input  logic [TAG_W-1:0]  clr_idx0,
  input  logic [TAG_W-1:0]  clr_idx1,
  input  logic [TAG_W-1:0]  rd_idx0,
  input  logic [TAG_W-1:0]  rd_idx1,
  output logic [REG_W-1:0]  rd_dst0,
  output logic [REG_W-1:0]  rd_dst1,
  output logic [DATA_W-1:0] rd_data0,
  output logic [DATA_W-1:0] rd_data1,
  output logic [1:0]        rd_store,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  done_vec
);

  logic [REG_W-1:0]  dst_arr   [DEPTH];
  logic [DATA_W-1:0] data_arr  [DEPTH];
  logic [DEPTH-1:0]  store_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] ME = TAG_W'(i);
    logic              v_q, d_q, s_q;
    logic [REG_W-1:0]  dst_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_clr, hit_cmpl, hit_sd, hit_w0, hit_w1;

    assign hit_clr  = (clr_en[0] && clr_idx0 == ME) || (clr_en[1] && clr_idx1 == ME);
    assign hit_cmpl = cmpl_en && cmpl_idx == ME;
    assign hit_sd   = sd_en && sd_idx == ME;
    assign hit_w0   = wr_en[0] && wr_idx0 == ME;
    assign hit_w1   = wr_en[1] && wr_idx1 == ME;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        d_q    <= 1'b0;
        s_q    <= 1'b0;
        dst_q  <= '0;
        data_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        if (hit_clr) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end
        if (hit_cmpl) begin
          d_q <= 1'b1;
          if (!s_q) data_q <= cmpl_data;
        end
        if (hit_sd) d_q <= 1'b1;
        if (hit_w0) begin
          v_q    <= 1'b1;
          d_q    <= 1'b0;
          s_q    <= wr_store[0];
          dst_q  <= wr_dst0;
          data_q <= '0;
        end
        if (hit_w1) begin
          v_q    <= 1'b1;
          d_q    <= 1'b0;
          s_q    <= wr_store[1];
          dst_q  <= wr_dst1;
          data_q <= '0;
        end
      end
    end

    assign valid_vec[i] = v_q;
    assign done_vec[i]  = d_q;
    assign store_vec[i] = s_q;
    assign dst_arr[i]   = dst_q;
    assign data_arr[i]  = data_q;
  end

  assign rd_dst0  = dst_arr[rd_idx0];
  assign rd_dst1  = dst_arr[rd_idx1];
  assign rd_data0 = data_arr[rd_idx0];
  assign rd_data1 = data_arr[rd_idx1];
  assign rd_store = {store_vec[rd_idx1], store_vec[rd_idx0]};

endmodule

// File: rtl/dual_commit_rob.sv
module dual_commit_rob #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 64,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        alloc_valid,
  input  logic              alloc_is_store0,
  input  logic              alloc_is_store1,
  input  logic [REG_W-1:0]  alloc_dst0,
  input  logic [REG_W-1:0]  alloc_dst1,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag0,
  output logic [TAG_W-1:0]  alloc_tag1,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_data,
  input  logic              st_done_valid,
  input  logic [TAG_W-1:0]  st_done_tag,
  output logic [1:0]        commit_valid,
  output logic [REG_W-1:0]  commit_dst0,
  output logic [REG_W-1:0]  commit_dst1,
  output logic [DATA_W-1:0] commit_data0,
  output logic [DATA_W-1:0] commit_data1,
  output logic [1:0]        commit_is_store,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [1:0]       n_alloc, n_commit;
  logic [1:0]       wr_en;
  logic [TAG_W-1:0] head_idx0, head_idx1;
  logic [DEPTH-1:0] valid_vec, done_vec;

  // Named events for the checker
  logic alloc_fire;
  logic retire_fire;

  rob_alloc_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) alloc_i (
    .alloc_valid (alloc_valid),
    .count       (count_q),
    .alloc_ready (alloc_ready),
    .n_alloc     (n_alloc)
  );

  assign alloc_tag0 = tail_q;
  assign alloc_tag1 = TAG_W'(rob_pkg::wrap_add(int'(tail_q), 1, DEPTH));
  assign wr_en      = alloc_ready ? alloc_valid : 2'b00;
  assign alloc_fire = |wr_en;

  rob_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W)) retire_i (
    .head         (head_q),
    .valid_vec    (valid_vec),
    .done_vec     (done_vec),
    .idx0         (head_idx0),
    .idx1         (head_idx1),
    .commit_valid (commit_valid),
    .n_commit     (n_commit)
  );

  assign retire_fire = commit_valid[0];

  rob_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) slots_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (wr_en),
    .wr_idx0   (alloc_tag0),
    .wr_idx1   (alloc_tag1),
    .wr_store  ({alloc_is_store1, alloc_is_store0}),
    .wr_dst0   (alloc_dst0),
    .wr_dst1   (alloc_dst1),
    .cmpl_en   (cmpl_valid),
    .cmpl_idx  (cmpl_tag),
    .cmpl_data (cmpl_data),
    .sd_en     (st_done_valid),
    .sd_idx    (st_done_tag),
    .clr_en    (commit_valid),
    .clr_idx0  (head_idx0),
    .clr_idx1  (head_idx1),
    .rd_idx0   (head_idx0),
    .rd_idx1   (head_idx1),
    .rd_dst0   (commit_dst0),
    .rd_dst1   (commit_dst1),
    .rd_data0  (commit_data0),
    .rd_data1  (commit_data1),
    .rd_store  (commit_is_store),
    .valid_vec (valid_vec),
    .done_vec  (done_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= TAG_W'(rob_pkg::wrap_add(int'(head_q), int'(n_commit), DEPTH));
      tail_q  <= TAG_W'(rob_pkg::wrap_add(int'(tail_q), int'(n_alloc), DEPTH));
      count_q <= CNT_W'(int'(count_q) + int'(n_alloc) - int'(n_commit));
    end
  end

  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [1:0]       alloc_valid,
  input logic             alloc_ready,
  input logic             alloc_fire,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic [TAG_W-1:0] head_q,
  input logic             cmpl_valid,
  input logic [TAG_W-1:0] cmpl_tag,
  input logic [1:0]       commit_valid,
  input logic             retire_fire
);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r3_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid != 2'b00) |-> (!alloc_ready && !alloc_fire));

  a_r6_lane1_needs_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid[1] |-> retire_fire);

  a_r4_head_retires_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_tag == head_q && count != '0 && !flush && !retire_fire)
      |=> commit_valid[0]);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && commit_valid == 2'b00));

endmodule

bind dual_commit_rob rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_fire   (alloc_fire),
  .full         (full),
  .count        (count),
  .head_q       (head_q),
  .cmpl_valid   (cmpl_valid),
  .cmpl_tag     (cmpl_tag),
  .commit_valid (commit_valid),
  .retire_fire  (retire_fire)
);

// File: tb/dual_commit_rob_tb_top.sv
module dual_commit_rob_tb_top;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 64, TAG_W = 3, CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [1:0] alloc_valid = '0;
  logic alloc_is_store0 = 1'b0, alloc_is_store1 = 1'b0;
  logic [REG_W-1:0] alloc_dst0 = '0, alloc_dst1 = '0;
  logic alloc_ready;
  logic [TAG_W-1:0] alloc_tag0, alloc_tag1;
  logic cmpl_valid = 1'b0;
  logic [TAG_W-1:0] cmpl_tag = '0;
  logic [DATA_W-1:0] cmpl_data = '0;
  logic st_done_valid = 1'b0;
  logic [TAG_W-1:0] st_done_tag = '0;
  logic [1:0] commit_valid, commit_is_store;
  logic [REG_W-1:0] commit_dst0, commit_dst1;
  logic [DATA_W-1:0] commit_data0, commit_data1;
  logic [CNT_W-1:0] count;
  logic full;

  always #10 clk = ~clk;

  dual_commit_rob #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) dut_i (.*);

  typedef struct {
    int               tag;
    logic [REG_W-1:0] dst;
    logic [63:0]      data;
    bit               st;
    bit               done;
  } ent_t;

  ent_t q[$];
  int tail_m = 0;
  int checks = 0, errors = 0;
  bit finished = 0, was_flush = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    int n = q.size();
    int want = int'(alloc_valid[0]) + int'(alloc_valid[1]);
    bit e0 = (n > 0) && q[0].done;
    bit e1 = e0 && (n > 1) && q[1].done;
    chk(int'(count) == n, "R8", "count", 64'(count), 64'(n));
    chk(full == (n == DEPTH), "R8", "full", 64'(full), 64'(n == DEPTH));
    chk(int'(alloc_tag0) == tail_m, "R2", "tag0", 64'(alloc_tag0), 64'(tail_m));
    chk(int'(alloc_tag1) == (tail_m + 1) % DEPTH, (tail_m == DEPTH - 1) ? "R9" : "R2",
        "tag1", 64'(alloc_tag1), 64'((tail_m + 1) % DEPTH));
    chk(alloc_ready == (DEPTH - n >= want), "R3", "alloc_ready",
        64'(alloc_ready), 64'(DEPTH - n >= want));
    chk(commit_valid[0] == e0, "R4", "commit_valid0", 64'(commit_valid[0]), 64'(e0));
    chk(commit_valid[1] == e1, "R6", "commit_valid1", 64'(commit_valid[1]), 64'(e1));
    if (e0) begin
      chk(commit_dst0 == q[0].dst, "R5", "dst0", 64'(commit_dst0), 64'(q[0].dst));
      chk(commit_data0 == q[0].data, "R5", "data0", commit_data0, q[0].data);
      chk(commit_is_store[0] == q[0].st, "R7", "store0", 64'(commit_is_store[0]), 64'(q[0].st));
    end
    if (e1) begin
      chk(commit_dst1 == q[1].dst, "R5", "dst1", 64'(commit_dst1), 64'(q[1].dst));
      chk(commit_data1 == q[1].data, "R5", "data1", commit_data1, q[1].data);
      chk(commit_is_store[1] == q[1].st, "R7", "store1", 64'(commit_is_store[1]), 64'(q[1].st));
    end
    if (was_flush)
      chk(count == '0 && alloc_tag0 == '0 && commit_valid == 2'b00, "R10", "after flush",
          {count, alloc_tag0, commit_valid}, 64'(0));
  endtask

  task automatic model_edge();
    int used = q.size();
    int want = int'(alloc_valid[0]) + int'(alloc_valid[1]);
    int ncom = 0;
    was_flush = 0;
    if (!rst_n || flush) begin
      q.delete();
      tail_m = 0;
      was_flush = flush && rst_n;
      return;
    end
    if (used > 0 && q[0].done) ncom = 1;
    if (ncom == 1 && used > 1 && q[1].done) ncom = 2;
    repeat (ncom) void'(q.pop_front());
    foreach (q[i]) begin
      if (cmpl_valid && q[i].tag == int'(cmpl_tag)) begin
        q[i].done = 1;
        if (!q[i].st) q[i].data = cmpl_data;
      end
      if (st_done_valid && q[i].tag == int'(st_done_tag)) q[i].done = 1;
    end
    if (DEPTH - used >= want) begin
      if (alloc_valid[0]) q.push_back('{tail_m, alloc_dst0, 64'd0, alloc_is_store0, 1'b0});
      if (alloc_valid[1]) q.push_back('{(tail_m + 1) % DEPTH, alloc_dst1, 64'd0, alloc_is_store1, 1'b0});
      tail_m = (tail_m + want) % DEPTH;
    end
  endtask

  task automatic step();
    #1;
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic gen(input int p_alloc, input int p_cmpl, input int p_flush);
    int pick[$];
    int spick[$];
    int r = int'($urandom % 100);
    alloc_valid = 2'b00;
    if (r < p_alloc) alloc_valid = ($urandom % 2 == 0) ? 2'b01 : 2'b11;
    alloc_is_store0 = ($urandom % 4 == 0);
    alloc_is_store1 = ($urandom % 4 == 0);
    alloc_dst0 = REG_W'($urandom);
    alloc_dst1 = REG_W'($urandom);
    foreach (q[i]) begin
      if (!q[i].done && !q[i].st) pick.push_back(q[i].tag);
      if (!q[i].done && q[i].st) spick.push_back(q[i].tag);
    end
    cmpl_valid = 1'b0;
    st_done_valid = 1'b0;
    if (pick.size() > 0 && int'($urandom % 100) < p_cmpl) begin
      cmpl_valid = 1'b1;
      cmpl_tag = TAG_W'(pick[$urandom % pick.size()]);
      cmpl_data = {$urandom, $urandom};
    end
    if (spick.size() > 0 && int'($urandom % 100) < p_cmpl) begin
      st_done_valid = 1'b1;
      st_done_tag = TAG_W'(spick[$urandom % spick.size()]);
    end
    flush = (int'($urandom % 1000) < p_flush);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: state during and after reset
    chk(count == '0 && !full && commit_valid == 2'b00 && alloc_tag0 == '0, "R1",
        "in reset", {count, full, commit_valid, alloc_tag0}, 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == '0 && !full && commit_valid == 2'b00 && alloc_tag0 == '0, "R1",
        "after reset", {count, full, commit_valid, alloc_tag0}, 64'(0));
    // fill with no completions: reaches full, then stalls (R3, R8)
    repeat (10) begin gen(100, 0, 0); step(); end
    // drain: completions only, in-order and paired retirement (R4 R5 R6 R7)
    repeat (30) begin gen(0, 90, 0); step(); end
    // mixed traffic with wrap and occasional flush (R9 R10)
    repeat (500) begin gen(60, 50, 8); step(); end
    // directed flush while requesting allocation (R10)
    gen(100, 50, 0);
    flush = 1'b1;
    step();
    repeat (400) begin gen(80, 35, 0); step(); end
    repeat (40) begin gen(0, 100, 0); step(); end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule